// File: doc/BRIEF.md
# Event Interrupt Flag and Mask Registers

This block holds the interrupt state for six external event channels. Separate input-processing logic detects each event and delivers it as a one-cycle pulse. The block records each pulse in a sticky per-channel flag. It keeps a per-channel mask that software sets. It drives one interrupt request line, which is active while any flagged channel is also unmasked.

Software reaches both bytes through a small synchronous register bus. A write uses a strobe, a byte offset and an 8-bit data value. A read returns the addressed byte combinationally. Flags are acknowledged by writing a 0 into their bit positions. A 1 in a bit position leaves that flag alone, so software can clear some flags without read-modify-write hazards on the others. A flag raised by hardware in the same cycle as a software clear survives, so no event is lost.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset, the flag byte and the mask byte both read 0x00 and `irq` is 0.
- R2: A 1 on `evt_pulse[n]` at a clock edge makes flag bit n read 1 after that edge.
- R3: A write to offset 0 clears each flag bit whose data bit is 0. Each flag bit whose data bit is 1 keeps its value.
- R4: When a pulse on channel n and a write of 0 to flag bit n come in the same cycle, flag bit n reads 1 afterwards.
- R5: A write to offset 1 loads data bits 0 to 5 into mask bits 0 to 5. Mask bit n at 1 enables channel n, and at 0 masks it.
- R6: A pulse sets its flag bit even when the channel's mask bit is 0.
- R7: `irq` is registered. After each clock edge it equals the OR over n of (flag n AND mask n), taken as they stood before that edge.
- R8: Bits 7 and 6 of both bytes always read 0. Writing 1 to them changes nothing.
- R9: The flag byte is read and written at offset 0 and the mask byte at offset 1. Offsets 2 and 3 read 0x00, and writes to them change neither byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 6 | One-cycle event pulses, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Byte offset for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed offset |
| irq | output | 1 | Combined interrupt request |

## Verification
A vector table drives pulses on masked and unmasked channels. It clears flags with partial zero patterns and with all-ones patterns, and it coincides a pulse with a clearing write. This separates a clear that acts only on zero bits from one that acts on every written bit, and shows whether set or clear wins the tie. Writes of 0xFF and writes to unused offsets show whether the upper bits or stray offsets can leak into state. The line `irq` is checked one cycle after each change, against the previous row's flag and mask, so a combinational or two-cycle output shows up as a mismatch.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int EVT_NUM_CH     = 6;
   localparam int EVT_DATA_W     = 8;
   localparam int EVT_ADDR_W     = 2;
   localparam int EVT_FLAG_OFS   = 0;
   localparam int EVT_MASK_OFS   = 1;
endpackage

// File: rtl/evt_status_bank.sv
// Sticky per-channel flags; a hardware set wins over a software clear (R4).
module evt_status_bank #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] flags_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_o[g] <= 1'b0;
         else if (set_i[g])
            flags_o[g] <= 1'b1;
         else if (clr_i[g])
            flags_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_enable_reg.sv
// Plain read/write mask register (R5).
module evt_enable_reg #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [NUM_CH-1:0] data_i,
   output logic [NUM_CH-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= '0;
      else if (load_i)
         mask_o <= data_i;
   end
endmodule

// File: rtl/evt_irq_merge.sv
// Combines flags with mask; registered or direct output chosen by parameter.
module evt_irq_merge #(
   parameter int NUM_CH     = 6,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flags_i,
   input  logic [NUM_CH-1:0] mask_i,
   output logic              irq_o
);
   logic pending;
   assign pending = |(flags_i & mask_i);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_o <= 1'b0;
         else
            irq_o <= pending;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign irq_o = pending;
   end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int NUM_CH         = EVT_NUM_CH,
   parameter int DATA_W         = EVT_DATA_W,
   parameter int ADDR_W         = EVT_ADDR_W,
   parameter int FLAG_OFS       = EVT_FLAG_OFS,
   parameter int MASK_OFS       = EVT_MASK_OFS,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_pulse,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int PAD_W = DATA_W - NUM_CH;
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

   initial begin
      assert (NUM_CH > 0 && NUM_CH < DATA_W)
         else $fatal(1, "NUM_CH must be in 1..DATA_W-1");
      assert (FLAG_OFS != MASK_OFS)
         else $fatal(1, "flag and mask offsets must differ");
      assert (FLAG_OFS < (1 << ADDR_W) && MASK_OFS < (1 << ADDR_W))
         else $fatal(1, "offsets must fit in ADDR_W");
   end

   logic [NUM_CH-1:0] status_q;
   logic [NUM_CH-1:0] enable_q;
   logic [NUM_CH-1:0] clr_vec;
   logic              hit_flag;
   logic              hit_mask;
   logic [PAD_W-1:0]  unused_wr_hi;

   assign unused_wr_hi = wr_data[DATA_W-1:NUM_CH];

   // R9: offset decode; R3: only zero data bits request a clear
   assign hit_flag = wr_en && (addr == FLAG_A);
   assign hit_mask = wr_en && (addr == MASK_A);
   assign clr_vec  = hit_flag ? ~wr_data[NUM_CH-1:0] : '0;

   evt_status_bank #(.NUM_CH(NUM_CH)) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_pulse),
      .clr_i   (clr_vec),
      .flags_o (status_q)
   );

   evt_enable_reg #(.NUM_CH(NUM_CH)) i_enable (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (hit_mask),
      .data_i (wr_data[NUM_CH-1:0]),
      .mask_o (enable_q)
   );

   evt_irq_merge #(.NUM_CH(NUM_CH), .REGISTERED(IRQ_REGISTERED)) i_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (status_q),
      .mask_i  (enable_q),
      .irq_o   (irq)
   );

   // R8: upper bits padded with zero; R9: other offsets read zero
   always_comb begin
      rd_data = '0;
      if (addr == FLAG_A)
         rd_data = {{PAD_W{1'b0}}, status_q};
      else if (addr == MASK_A)
         rd_data = {{PAD_W{1'b0}}, enable_q};
   end
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk #(
   parameter int NUM_CH   = 6,
   parameter int PAD_W    = 2,
   parameter int ADDR_W   = 2,
   parameter int FLAG_OFS = 0,
   parameter int MASK_OFS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] evt_pulse,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [NUM_CH-1:0] wr_lo,
   input logic [PAD_W-1:0]  rd_hi,
   input logic [NUM_CH-1:0] status,
   input logic [NUM_CH-1:0] enable,
   input logic              irq
);
   logic wr_flag;
   logic wr_mask;
   assign wr_flag = wr_en && (addr == ADDR_W'(FLAG_OFS));
   assign wr_mask = wr_en && (addr == ADDR_W'(MASK_OFS));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      // R2, R4, R6: a pulse always leaves the flag set
      a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[g] |=> status[g]);
      // R3: zero data bit clears when no pulse
      a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_flag && !wr_lo[g] && !evt_pulse[g]) |=> !status[g]);
      // R3: a flag stays set unless a zero is written to it
      a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (status[g] && !(wr_flag && !wr_lo[g])) |=> status[g]);
   end

   // R5: mask load
   a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (enable == $past(wr_lo)));
   // R5, R9: mask untouched without a write to its offset
   a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(enable));
   // R7: registered combine
   a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(status & enable)));
   // R8: upper read bits are zero
   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi == '0);
endmodule

bind evt_irq_regs evt_irq_regs_chk #(
   .NUM_CH   (NUM_CH),
   .PAD_W    (PAD_W),
   .ADDR_W   (ADDR_W),
   .FLAG_OFS (FLAG_OFS),
   .MASK_OFS (MASK_OFS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_pulse (evt_pulse),
   .wr_en     (wr_en),
   .addr      (addr),
   .wr_lo     (wr_data[NUM_CH-1:0]),
   .rd_hi     (rd_data[DATA_W-1:NUM_CH]),
   .status    (status_q),
   .enable    (enable_q),
   .irq       (irq)
);

// File: tb/test_evt_irq_regs.sv
module test_evt_irq_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt_pulse = '0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   evt_irq_regs i_evt_irq_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .irq       (irq)
   );

   // Row: {pulses, wr_en, offset, data, expected flags, expected mask}
   localparam int NV = 14;
   localparam logic [28:0] VEC [NV] = '{
      {6'h01, 1'b0, 2'd0, 8'h00, 6'h01, 6'h00}, // R2 pulse ch0
      {6'h00, 1'b1, 2'd1, 8'h05, 6'h01, 6'h05}, // R5 mask ch0,ch2
      {6'h00, 1'b0, 2'd0, 8'h00, 6'h01, 6'h05}, // idle
      {6'h02, 1'b0, 2'd0, 8'h00, 6'h03, 6'h05}, // R6 masked ch1 still flags
      {6'h00, 1'b1, 2'd0, 8'hFE, 6'h02, 6'h05}, // R3 clear ch0 only
      {6'h00, 1'b1, 2'd0, 8'hFF, 6'h02, 6'h05}, // R3 ones keep
      {6'h10, 1'b1, 2'd0, 8'h00, 6'h10, 6'h05}, // R4 set beats clear
      {6'h00, 1'b1, 2'd1, 8'hFF, 6'h10, 6'h3F}, // R8 upper bits dropped
      {6'h00, 1'b1, 2'd3, 8'h00, 6'h10, 6'h3F}, // R9 stray offset write
      {6'h3F, 1'b0, 2'd0, 8'h00, 6'h3F, 6'h3F}, // R2 all channels
      {6'h00, 1'b1, 2'd0, 8'hC0, 6'h00, 6'h3F}, // R3 clear all, top ones
      {6'h00, 1'b1, 2'd1, 8'h00, 6'h00, 6'h00}, // R5 mask off
      {6'h20, 1'b1, 2'd1, 8'h20, 6'h20, 6'h20}, // R5 R2 same edge
      {6'h00, 1'b0, 2'd0, 8'h00, 6'h20, 6'h20}  // R7 irq one cycle later
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_byte(input logic [1:0] ofs, output logic [7:0] val);
      addr = ofs;
      #1;
      val = rd_data;
   endtask

   initial begin
      logic [7:0] v;
      logic [5:0] prev_s;
      logic [5:0] prev_e;
      // R1 reset state
      #10;
      read_byte(2'd0, v); chk("R1 flags in reset", v, 8'h00);
      read_byte(2'd1, v); chk("R1 mask in reset", v, 8'h00);
      chk("R1 irq in reset", {7'd0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      prev_s = '0;
      prev_e = '0;

      for (int i = 0; i < NV; i++) begin
         evt_pulse = VEC[i][28:23];
         wr_en     = VEC[i][22];
         addr      = VEC[i][21:20];
         wr_data   = VEC[i][19:12];
         @(posedge clk);
         @(negedge clk);
         evt_pulse = '0;
         wr_en     = 1'b0;
         wr_data   = '0;
         read_byte(2'd0, v);
         chk($sformatf("R2 R3 R4 R6 R8 flags row %0d", i), v, {2'b00, VEC[i][11:6]});
         read_byte(2'd1, v);
         chk($sformatf("R5 R8 R9 mask row %0d", i), v, {2'b00, VEC[i][5:0]});
         chk($sformatf("R7 irq row %0d", i), {7'd0, irq}, {7'd0, |(prev_s & prev_e)});
         prev_s = VEC[i][11:6];
         prev_e = VEC[i][5:0];
      end

      // R9: unused offsets read zero while both bytes hold data
      read_byte(2'd2, v); chk("R9 offset 2 reads zero", v, 8'h00);
      read_byte(2'd3, v); chk("R9 offset 3 reads zero", v, 8'h00);

      // R8: write ones everywhere to mask, upper bits stay zero
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd1; wr_data = 8'hFF;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      read_byte(2'd1, v); chk("R8 mask upper bits", v & 8'hC0, 8'h00);

      // R7: irq stays high while flag and mask hold, then drops one cycle after clear
      @(negedge clk);
      chk("R7 irq held", {7'd0, irq}, 8'h01);
      wr_en = 1'b1; addr = 2'd0; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 irq still high right after clear", {7'd0, irq}, 8'h01);
      @(negedge clk);
      chk("R7 irq low after clear", {7'd0, irq}, 8'h00);

      // R1: reset mid-run clears everything
      evt_pulse = 6'h3F;
      @(negedge clk);
      evt_pulse = '0;
      rst_n = 1'b0;
      #1;
      read_byte(2'd0, v); chk("R1 flags after reset", v, 8'h00);
      read_byte(2'd1, v); chk("R1 mask after reset", v, 8'h00);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule